// File: doc/BRIEF.md
# Single-Accumulator Sequencing Core

This block is a compact processor core that executes programs of 16-bit instruction words. Each word has a 4-bit operation code in bits [15:12] and a 12-bit direct word address in bits [11:0]. The core holds three registers: a program counter, a 16-bit two's-complement accumulator and an instruction register. It reaches one shared synchronous memory through a single port. When the port carries an address on one clock edge, the read data for that address is returned on the next edge. A write is a single-cycle pulse of `mem_we` with the data on `mem_wdata`.

Every instruction takes three clock cycles. In the first cycle the core presents the program counter to memory. In the second it captures the instruction word, advances the program counter by one word and presents the operand address. In the third it executes: it updates the accumulator, issues a store, or loads a jump target into the program counter. A stop instruction moves the core into a halted state. In that state it keeps all its registers, fetches nothing and never writes. The only way out is reset.

Top module: `acc_core`

## Requirements
- R1: While reset is held and after it is released, `halted` is 0, `mem_we` is 0 and the first fetch is from word address 0. Reset clears the accumulator.
- R2: Opcode 0000 loads the accumulator with the word at the operand address. Opcode 0001 writes the accumulator to the operand address.
- R3: Opcode 0010 adds the word at the operand address to the accumulator. Opcode 0011 subtracts that word from the accumulator. Both wrap modulo 2^16.
- R4: Opcode 0100 always sets the program counter to the operand address.
- R5: Opcode 0101 jumps to the operand address only when accumulator bit 15 is 0, which includes the value zero. Otherwise execution continues with the next word.
- R6: Opcode 0110 jumps to the operand address only when the accumulator is non-zero.
- R7: Opcode 0111 raises `halted`. From then on `halted` stays 1, `mem_we` stays 0 and `mem_addr` does not change.
- R8: Opcodes 1000 through 1111 leave the accumulator unchanged and do not write memory. Execution continues with the next word.
- R9: Every instruction takes exactly three clock cycles. A program of N instructions that ends in a stop raises `halted` on the 3N-th rising edge after reset is released. `mem_we` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 12 | Word address to memory |
| mem_wdata | output | 16 | Data written to memory |
| mem_we | output | 1 | Write strobe, one cycle per store |
| mem_rdata | input | 16 | Word read from the address presented on the previous edge |
| halted | output | 1 | High once a stop instruction has executed |

## Verification
The bench runs arithmetic on the boundaries where overflow wraps: 0x7FFF+1, 0xFFFF+1, 0x8000-1 and 0-0x8000. A core that sign-extended, saturated or reversed the operands of the subtraction would store the wrong word.

The conditional jumps are tried at accumulator values 0, 0x7FFF, 0x8000 and 1. A core that used "strictly positive" for the sign test, or tested bit 0 instead of the whole word, would either skip a store it should perform or perform one it should skip.

Every undefined opcode is placed between a load and a store, with an address field that points at a marker word. A core that decoded only three opcode bits would treat these as real instructions and corrupt the marker or the accumulator.

A counting loop measures the exact number of cycles to the halt. After the halt, the bench watches the bus for stray fetches or writes.

// File: rtl/acc_pkg.sv
package acc_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 12;
    localparam int OP_W   = DATA_W - ADDR_W;

    localparam logic [OP_W-1:0] OP_LOAD  = 4'b0000;
    localparam logic [OP_W-1:0] OP_STORE = 4'b0001;
    localparam logic [OP_W-1:0] OP_ADD   = 4'b0010;
    localparam logic [OP_W-1:0] OP_SUB   = 4'b0011;
    localparam logic [OP_W-1:0] OP_JUMP  = 4'b0100;
    localparam logic [OP_W-1:0] OP_JPOS  = 4'b0101;
    localparam logic [OP_W-1:0] OP_JNZ   = 4'b0110;
    localparam logic [OP_W-1:0] OP_STOP  = 4'b0111;

    typedef enum logic [1:0] {
        ST_FETCH  = 2'd0,
        ST_DECODE = 2'd1,
        ST_EXEC   = 2'd2,
        ST_HALT   = 2'd3
    } phase_t;

    typedef struct packed {
        phase_t              phase;
        logic [ADDR_W-1:0]   pc;
        logic [DATA_W-1:0]   acc;
        logic [DATA_W-1:0]   ir;
    } core_regs_t;
endpackage

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
(
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] acc_out
);
    always_comb begin
        case (op)
            OP_LOAD: acc_out = operand;
            OP_ADD:  acc_out = acc_in + operand;
            OP_SUB:  acc_out = acc_in - operand;
            default: acc_out = acc_in;
        endcase
    end
endmodule

// File: rtl/acc_branch.sv
module acc_branch
    import acc_pkg::*;
(
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [ADDR_W-1:0] pc_seq,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] pc_out,
    output logic              taken
);
    logic acc_nonneg;
    logic acc_nonzero;

    assign acc_nonneg  = ~acc_in[DATA_W-1];
    assign acc_nonzero = |acc_in;

    always_comb begin
        case (op)
            OP_JUMP: taken = 1'b1;
            OP_JPOS: taken = acc_nonneg;
            OP_JNZ:  taken = acc_nonzero;
            default: taken = 1'b0;
        endcase
        pc_out = taken ? target : pc_seq;
    end
endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic [11:0]       mem_addr,
    output logic [15:0]       mem_wdata,
    output logic              mem_we,
    input  logic [15:0]       mem_rdata,
    output logic              halted
);
    core_regs_t cur_q, nxt_d;

    logic [OP_W-1:0]   op_q;
    logic [ADDR_W-1:0] opnd_q;
    logic [DATA_W-1:0] alu_acc_d;
    logic [ADDR_W-1:0] br_pc_d;
    logic              br_taken_d;

    assign op_q   = cur_q.ir[DATA_W-1:ADDR_W];
    assign opnd_q = cur_q.ir[ADDR_W-1:0];

    acc_alu u_alu (
        .op      (op_q),
        .acc_in  (cur_q.acc),
        .operand (mem_rdata),
        .acc_out (alu_acc_d)
    );

    acc_branch u_branch (
        .op     (op_q),
        .acc_in (cur_q.acc),
        .pc_seq (cur_q.pc),
        .target (opnd_q),
        .pc_out (br_pc_d),
        .taken  (br_taken_d)
    );

    always_comb begin
        nxt_d     = cur_q;
        mem_addr  = cur_q.pc;
        mem_we    = 1'b0;
        mem_wdata = cur_q.acc;
        case (cur_q.phase)
            ST_FETCH: begin
                mem_addr    = cur_q.pc;
                nxt_d.phase = ST_DECODE;
            end
            ST_DECODE: begin
                nxt_d.ir    = mem_rdata;
                nxt_d.pc    = cur_q.pc + 1'b1;
                mem_addr    = mem_rdata[ADDR_W-1:0];
                nxt_d.phase = ST_EXEC;
            end
            ST_EXEC: begin
                mem_addr    = opnd_q;
                mem_we      = (op_q == OP_STORE);
                nxt_d.acc   = alu_acc_d;
                nxt_d.pc    = br_pc_d;
                nxt_d.phase = (op_q == OP_STOP) ? ST_HALT : ST_FETCH;
            end
            default: begin
                mem_addr    = cur_q.pc;
                nxt_d.phase = ST_HALT;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.phase <= ST_FETCH;
            cur_q.pc    <= '0;
            cur_q.acc   <= '0;
            cur_q.ir    <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign halted = (cur_q.phase == ST_HALT);

    AST_LOAD_TAKES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.phase == ST_EXEC && op_q == OP_LOAD) |=> cur_q.acc == $past(mem_rdata)); // R2
    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.phase == ST_EXEC && op_q == OP_JUMP) |=> cur_q.pc == $past(opnd_q)); // R4
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !mem_we && $stable(mem_addr))); // R7
    AST_UNDEF_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.phase == ST_EXEC && op_q[OP_W-1]) |=> $stable(cur_q.acc)); // R8
    AST_UNDEF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.phase == ST_EXEC && op_q[OP_W-1]) |-> !mem_we); // R8
    AST_WE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we); // R9
endmodule

// File: tb/tb_acc_core.sv
`timescale 1ns/1ps
module tb_acc_core;
    localparam logic [3:0] I_LDA = 4'h0, I_STO = 4'h1, I_ADD = 4'h2, I_SUB = 4'h3,
                           I_JMP = 4'h4, I_JGE = 4'h5, I_JNE = 4'h6, I_STP = 4'h7;
    localparam int NVEC = 8;
    // {is_sub, a, b, expected}
    localparam logic [48:0] VEC [NVEC] = '{
        {1'b0, 16'h0003, 16'h0004, 16'h0007},
        {1'b1, 16'h0003, 16'h0004, 16'hFFFF},
        {1'b0, 16'h7FFF, 16'h0001, 16'h8000},
        {1'b0, 16'hFFFF, 16'h0001, 16'h0000},
        {1'b1, 16'h8000, 16'h0001, 16'h7FFF},
        {1'b1, 16'h1234, 16'h1234, 16'h0000},
        {1'b0, 16'h1234, 16'h4321, 16'h5555},
        {1'b1, 16'h0000, 16'h8000, 16'h8000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic [15:0] mem_rdata;
    logic        halted;

    logic [15:0] mem [256];
    logic        ld_clr = 1'b0, ld_we = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;

    int checks = 0, failures = 0, cycles = 0;

    always #5 clk = ~clk;

    acc_core dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted)
    );

    always @(posedge clk) begin
        if (ld_clr) begin
            for (int i = 0; i < 256; i++) mem[i] <= 16'h0000;
        end else if (ld_we) begin
            mem[ld_addr] <= ld_data;
        end else if (mem_we) begin
            mem[mem_addr[7:0]] <= mem_wdata;
        end
        mem_rdata <= mem[mem_addr[7:0]];
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired: actual=%0d expected<150000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] a);
        return {op, a};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [7:0] a, input logic [15:0] d);
        ld_addr = a; ld_data = d; ld_we = 1'b1;
        @(posedge clk); #1;
        ld_we = 1'b0;
    endtask

    task automatic start_load();
        @(posedge clk); #1;
        rst_n = 1'b0;
        ld_clr = 1'b1;
        @(posedge clk); #1;
        ld_clr = 1'b0;
    endtask

    task automatic run(output int edges);
        rst_n = 1'b1;
        edges = 0;
        while (!halted && edges < 400) begin
            @(posedge clk); #1;
            edges++;
        end
    endtask

    // Program: LDA 0x80; <op> 3; STO 0x90; STP   (marker 0xAAAA at 0x90)
    task automatic branch_case(input string req, input logic [3:0] op,
                               input logic [15:0] val, input bit expect_taken);
        int e;
        start_load();
        poke(8'h00, ins(I_LDA, 12'h080));
        poke(8'h01, ins(op, 12'h003));
        poke(8'h02, ins(I_STO, 12'h090));
        poke(8'h03, ins(I_STP, 12'h000));
        poke(8'h80, val);
        poke(8'h90, 16'hAAAA);
        run(e);
        check(req, mem[8'h90], expect_taken ? 16'hAAAA : val);
    endtask

    initial begin
        int e;
        // R1: reset state
        start_load();
        poke(8'h00, ins(I_STP, 12'h000));
        #2;
        check("R1 halted in reset", {15'd0, halted}, 16'h0000);
        check("R1 we in reset", {15'd0, mem_we}, 16'h0000);
        rst_n = 1'b1;
        #1;
        check("R1 first fetch address", {4'h0, mem_addr}, 16'h0000);
        check("R1 halted after release", {15'd0, halted}, 16'h0000);

        // R1: accumulator cleared by reset (store before any load)
        start_load();
        poke(8'h00, ins(I_STO, 12'h090));
        poke(8'h01, ins(I_STP, 12'h000));
        poke(8'h90, 16'h5A5A);
        run(e);
        check("R1 acc cleared", mem[8'h90], 16'h0000);

        // R2/R3/R9: vector table
        for (int v = 0; v < NVEC; v++) begin
            start_load();
            poke(8'h00, ins(I_LDA, 12'h080));
            poke(8'h01, ins(VEC[v][48] ? I_SUB : I_ADD, 12'h081));
            poke(8'h02, ins(I_STO, 12'h082));
            poke(8'h03, ins(I_STP, 12'h000));
            poke(8'h80, VEC[v][47:32]);
            poke(8'h81, VEC[v][31:16]);
            run(e);
            check("R3 add/sub result", mem[8'h82], VEC[v][15:0]);
            check("R2 operand left intact", mem[8'h80], VEC[v][47:32]);
            check("R9 cycles to halt", 16'(e), 16'd12);
        end

        // R4: unconditional jump skips store
        start_load();
        poke(8'h00, ins(I_LDA, 12'h080));
        poke(8'h01, ins(I_JMP, 12'h003));
        poke(8'h02, ins(I_STO, 12'h090));
        poke(8'h03, ins(I_STP, 12'h000));
        poke(8'h80, 16'h8001);
        poke(8'h90, 16'hAAAA);
        run(e);
        check("R4 jump taken", mem[8'h90], 16'hAAAA);

        // R5 / R6: conditional jumps
        branch_case("R5 zero taken",        I_JGE, 16'h0000, 1'b1);
        branch_case("R5 max positive taken", I_JGE, 16'h7FFF, 1'b1);
        branch_case("R5 negative not taken", I_JGE, 16'h8000, 1'b0);
        branch_case("R5 minus one not taken", I_JGE, 16'hFFFF, 1'b0);
        branch_case("R6 zero not taken",    I_JNE, 16'h0000, 1'b0);
        branch_case("R6 one taken",         I_JNE, 16'h0001, 1'b1);
        branch_case("R6 sign only taken",   I_JNE, 16'h8000, 1'b1);

        // R6/R9: countdown loop LDA;SUB;STO;JNE 1;STP with x=3 -> 11 instructions
        start_load();
        poke(8'h00, ins(I_LDA, 12'h080));
        poke(8'h01, ins(I_SUB, 12'h081));
        poke(8'h02, ins(I_STO, 12'h080));
        poke(8'h03, ins(I_JNE, 12'h001));
        poke(8'h04, ins(I_STP, 12'h000));
        poke(8'h80, 16'h0003);
        poke(8'h81, 16'h0001);
        run(e);
        check("R6 loop final value", mem[8'h80], 16'h0000);
        check("R9 loop cycles", 16'(e), 16'd33);

        // R8: undefined opcodes with address field pointing at marker 0x90
        for (int op = 8; op < 16; op++) begin
            start_load();
            poke(8'h00, ins(I_LDA, 12'h080));
            poke(8'h01, ins(4'(op), 12'h090));
            poke(8'h02, ins(I_STO, 12'h091));
            poke(8'h03, ins(I_STP, 12'h000));
            poke(8'h80, 16'h1111);
            poke(8'h90, 16'hAAAA);
            run(e);
            check("R8 acc unchanged", mem[8'h91], 16'h1111);
            check("R8 marker untouched", mem[8'h90], 16'hAAAA);
        end

        // R7: stop freezes the core
        start_load();
        poke(8'h00, ins(I_LDA, 12'h080));
        poke(8'h01, ins(I_STP, 12'h000));
        poke(8'h02, ins(I_STO, 12'h090));
        poke(8'h80, 16'h4242);
        poke(8'h90, 16'hAAAA);
        run(e);
        check("R7 halted", {15'd0, halted}, 16'h0001);
        check("R9 stop cycles", 16'(e), 16'd6);
        begin
            logic [11:0] held;
            bit bad;
            held = mem_addr;
            bad = 1'b0;
            for (int k = 0; k < 10; k++) begin
                @(posedge clk); #1;
                if (mem_we || !halted || mem_addr != held) bad = 1'b1;
            end
            check("R7 bus frozen after stop", {15'd0, bad}, 16'h0000);
        end
        check("R7 no store after stop", mem[8'h90], 16'hAAAA);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule